// File: doc/BRIEF.md
# Cross-Clock Register Synchronization Bridge

This block links a register bank that is written and read from a bus clock domain to logic that runs on a separate core clock. Each register index carries a synchronization class, set by two parameter masks, and every bus access is handled according to that class. Writes to write-synchronized registers and reads of read-synchronized registers are carried across the clock boundary by a toggle request and a toggle acknowledge. Each of these two signals passes through a chain of flip-flops in the receiving domain. All other accesses finish locally in a single bus cycle.

A busy status rises in the cycle of a synchronized access and stays high until the acknowledge returns. Its fall comes with a one-cycle ready pulse that can feed an interrupt flag. A second synchronized access that arrives while busy is stalled through a wait signal and is never dropped. For a synchronized read, the core-domain value is sampled when the request arrives in the core domain. It becomes the read data in the cycle that busy falls.

Top module: `xclk_reg_sync`

## Requirements
- R1: Register i is write-synchronized when bit i of WR_SYNC is 1 and read-synchronized when bit i of RD_SYNC is 1. Both bits, one bit or neither may be set. The defaults are: registers 0 and 1 in both classes, 2 and 3 write only, 4 and 5 read only, 6 and 7 neither.
- R2: A synchronized access (bus_sel high, bus_we selecting the write or read class) with busy low drives bus_busy high in that same cycle. bus_busy then stays high until the handshake completes.
- R3: bus_busy falls within a bounded number of bus cycles after the accepting edge. After a synchronized write, core_q_o carries the written value once bus_busy is low.
- R4: sync_ready is high for exactly one bus cycle: the first cycle in which bus_busy is low after a synchronized access.
- R5: An unsynchronized access never raises bus_busy and is never stalled by a pending synchronized write. Its write reaches core_q_o, and its read reaches bus_rdata, in the cycle after the accepting edge.
- R6: A synchronized access attempted while busy drives bus_wait high and is not accepted. It is accepted once bus_wait drops.
- R7: A read of a read-synchronized register returns that register's slice of core_stat_i as sampled in the core domain. The value is on bus_rdata in the first cycle that bus_busy is low.
- R8: The value written to the core copy is the bus_wdata of the accepting cycle, even if bus_wdata changes before the handshake ends.
- R9: While a synchronized read is pending, an unsynchronized read is stalled through bus_wait, so that the pending read result is not overwritten.
- R10: After reset, bus_busy, bus_wait, sync_ready, bus_rdata and core_q_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| bus_sel | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Register index |
| bus_wdata | input | DW | Write data |
| bus_wait | output | 1 | Access stalled; hold the request |
| bus_busy | output | 1 | Synchronization in progress |
| bus_rdata | output | DW | Read data |
| sync_ready | output | 1 | One-cycle pulse when synchronization completes |
| core_clk | input | 1 | Core clock |
| core_rst | input | 1 | Synchronous active-high reset, core domain |
| core_stat_i | input | NREG*DW | Core-domain values returned by synchronized reads, one DW slice per register |
| core_q_o | output | NREG*DW | Register values presented to the core, one DW slice per register |

## Verification
The bench builds the block with eight 16-bit registers and masks that cover all four classes, two registers per class. This puts back-to-back stalls, mixed synchronized and unsynchronized traffic, and every class of read and write within reach of both the directed and the random stimulus. The core clock runs at a period of 7 ns against the 10 ns bus clock. Because the two clocks are unrelated, the phase of each request edge differs from one access to the next, which varies the handshake latency.

// File: rtl/xclk_sync_pkg.sv
package xclk_sync_pkg;
  typedef enum logic [1:0] {
    SC_NONE = 2'b00,
    SC_WR   = 2'b01,
    SC_RD   = 2'b10,
    SC_BOTH = 2'b11
  } sync_class_e;

  function automatic sync_class_e class_of(input logic wr_bit, input logic rd_bit);
    return sync_class_e'({rd_bit, wr_bit});
  endfunction

  function automatic logic access_synced(input sync_class_e c, input logic is_write);
    return is_write ? c[0] : c[1];
  endfunction
endpackage

// File: rtl/xclk_bit_sync.sv
module xclk_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/xclk_bus_side.sv
module xclk_bus_side
  import xclk_sync_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW = 16,
  parameter logic [NREG-1:0] WR_SYNC = '0,
  parameter logic [NREG-1:0] RD_SYNC = '0,
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sel,
  input  logic                we,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  output logic                wait_o,
  output logic                busy_o,
  output logic [DW-1:0]       rdata,
  output logic                ready_o,
  output logic                req_tgl,
  input  logic                ack_s,
  output logic                h_we,
  output logic [AW-1:0]       h_addr,
  output logic [DW-1:0]       h_data,
  input  logic [DW-1:0]       cap,
  output logic [NREG*DW-1:0]  shadow_o
);
  logic [NREG-1:0][DW-1:0] shadow;
  logic busy_q, rdy_q, need, start, done, stall;
  sync_class_e cls;

  assign cls    = class_of(WR_SYNC[addr], RD_SYNC[addr]);
  assign need   = sel & access_synced(cls, we);
  assign stall  = sel & busy_q & (need | (~we & ~h_we));
  assign start  = need & ~busy_q;
  assign done   = busy_q & (ack_s == req_tgl);
  assign wait_o = stall;
  assign busy_o = busy_q | start;
  assign ready_o = rdy_q;
  assign shadow_o = shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow  <= '0;
      busy_q  <= 1'b0;
      rdy_q   <= 1'b0;
      req_tgl <= 1'b0;
      h_we    <= 1'b1;
      h_addr  <= '0;
      h_data  <= '0;
      rdata   <= '0;
    end else begin
      rdy_q <= 1'b0;
      if (start) begin
        req_tgl <= ~req_tgl;
        busy_q  <= 1'b1;
        h_we    <= we;
        h_addr  <= addr;
        if (we) h_data <= wdata;
      end else if (done) begin
        busy_q <= 1'b0;
        rdy_q  <= 1'b1;
        if (!h_we) rdata <= cap;
      end
      if (sel && we && !stall) shadow[addr] <= wdata;
      if (sel && !we && !need && !stall) rdata <= shadow[addr];
    end
  end

  p_ready_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> rdy_q);
  p_ready_single_r4: assert property (@(posedge clk) disable iff (rst)
    rdy_q |=> !rdy_q);
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> ($stable(h_data) && $stable(h_addr) && $stable(h_we)));
  p_unsynced_no_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (sel && !need && !busy_q) |=> !busy_q);
  p_stall_not_taken_r6: assert property (@(posedge clk) disable iff (rst)
    wait_o |=> (req_tgl == $past(req_tgl)));
endmodule

// File: rtl/xclk_core_side.sv
module xclk_core_side #(
  parameter int NREG = 8,
  parameter int DW = 16,
  parameter logic [NREG-1:0] WR_SYNC = '0,
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_s,
  output logic               ack_tgl,
  input  logic               h_we,
  input  logic [AW-1:0]      h_addr,
  input  logic [DW-1:0]      h_data,
  output logic [DW-1:0]      cap,
  input  logic [NREG*DW-1:0] stat_i,
  input  logic [NREG*DW-1:0] shadow_i,
  output logic [NREG*DW-1:0] q_o
);
  logic pend;
  assign pend = (req_s != ack_tgl);

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_tgl <= 1'b0;
      cap     <= '0;
    end else if (pend) begin
      ack_tgl <= req_s;
      if (!h_we) cap <= stat_i[h_addr*DW +: DW];
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (WR_SYNC[i]) begin : g_sync
      logic [DW-1:0] val;
      always_ff @(posedge clk) begin
        if (rst) val <= '0;
        else if (pend && h_we && h_addr == AW'(i)) val <= h_data;
      end
      assign q_o[i*DW +: DW] = val;
    end else begin : g_plain
      assign q_o[i*DW +: DW] = shadow_i[i*DW +: DW];
    end
  end

  p_ack_only_when_pending_r3: assert property (@(posedge clk) disable iff (rst)
    (ack_tgl != $past(ack_tgl)) |-> $past(pend));
endmodule

// File: rtl/xclk_reg_sync.sv
module xclk_reg_sync #(
  parameter int NREG = 8,
  parameter int DW = 16,
  parameter int STAGES = 2,
  parameter logic [NREG-1:0] WR_SYNC = 8'b0000_1111,
  parameter logic [NREG-1:0] RD_SYNC = 8'b0011_0011,
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               bus_clk,
  input  logic               bus_rst,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic               bus_wait,
  output logic               bus_busy,
  output logic [DW-1:0]      bus_rdata,
  output logic               sync_ready,
  input  logic               core_clk,
  input  logic               core_rst,
  input  logic [NREG*DW-1:0] core_stat_i,
  output logic [NREG*DW-1:0] core_q_o
);
  logic req_tgl, req_s, ack_tgl, ack_s, h_we;
  logic [AW-1:0] h_addr;
  logic [DW-1:0] h_data, cap;
  logic [NREG*DW-1:0] shadow;

  xclk_bus_side #(.NREG(NREG), .DW(DW), .WR_SYNC(WR_SYNC), .RD_SYNC(RD_SYNC)) u_bus (
    .clk(bus_clk), .rst(bus_rst), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .wait_o(bus_wait), .busy_o(bus_busy), .rdata(bus_rdata),
    .ready_o(sync_ready), .req_tgl(req_tgl), .ack_s(ack_s), .h_we(h_we),
    .h_addr(h_addr), .h_data(h_data), .cap(cap), .shadow_o(shadow));

  xclk_bit_sync #(.STAGES(STAGES)) u_req_sync (
    .clk(core_clk), .rst(core_rst), .d(req_tgl), .q(req_s));

  xclk_bit_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk(bus_clk), .rst(bus_rst), .d(ack_tgl), .q(ack_s));

  xclk_core_side #(.NREG(NREG), .DW(DW), .WR_SYNC(WR_SYNC)) u_core (
    .clk(core_clk), .rst(core_rst), .req_s(req_s), .ack_tgl(ack_tgl),
    .h_we(h_we), .h_addr(h_addr), .h_data(h_data), .cap(cap),
    .stat_i(core_stat_i), .shadow_i(shadow), .q_o(core_q_o));
endmodule

// File: tb/tb_xclk_reg_sync.sv
module tb_xclk_reg_sync;
  localparam int NREG = 8, DW = 16, AW = 3;
  localparam logic [NREG-1:0] WRS = 8'b0000_1111, RDS = 8'b0011_0011;

  logic bus_clk = 0, core_clk = 0, bus_rst = 1, core_rst = 1;
  logic bus_sel = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_wait, bus_busy, sync_ready;
  logic [DW-1:0] bus_rdata;
  logic [NREG*DW-1:0] core_stat = '0, core_q;

  int checks = 0, fails = 0;
  logic [DW-1:0] mdl_shadow [NREG];
  logic [DW-1:0] mdl_core [NREG];

  always #5 bus_clk = ~bus_clk;
  always #3.5 core_clk = ~core_clk;

  xclk_reg_sync dut (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wait(bus_wait),
    .bus_busy(bus_busy), .bus_rdata(bus_rdata), .sync_ready(sync_ready),
    .core_clk(core_clk), .core_rst(core_rst), .core_stat_i(core_stat),
    .core_q_o(core_q));

  function automatic logic synced(input logic we, input int a);
    return we ? WRS[a] : RDS[a];
  endfunction

  function automatic logic [DW-1:0] exp_q(input int a);
    return WRS[a] ? mdl_core[a] : mdl_shadow[a];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (bus_busy && n < 60) begin @(negedge bus_clk); n++; end
    chk({req, " busy clears (R3)"}, {31'b0, bus_busy}, 0);
    chk("R4 ready pulse", {31'b0, sync_ready}, 1);
    @(negedge bus_clk);
    chk("R4 ready single cycle", {31'b0, sync_ready}, 0);
  endtask

  task automatic access(input logic we, input int a, input logic [DW-1:0] d);
    logic s = synced(we, a);
    bus_sel = 1; bus_we = we; bus_addr = AW'(a); bus_wdata = d;
    #1;
    while (bus_wait) @(negedge bus_clk);
    if (s) chk("R2 busy in access cycle", {31'b0, bus_busy}, 1);
    else   chk("R5 no busy for unsynced", {31'b0, bus_busy}, 0);
    @(negedge bus_clk);
    bus_sel = 0;
    bus_wdata = ~d;
    if (we) mdl_shadow[a] = d;
    if (s) begin
      if (we) begin
        chk("R3 core copy not yet updated", core_q[a*DW +: DW], exp_q(a));
        mdl_core[a] = d;
      end
      wait_idle(we ? "R1 write" : "R1 read");
      if (we) chk("R8 core value equals accepted data", core_q[a*DW +: DW], d);
      else    chk("R7 synced read data", bus_rdata, core_stat[a*DW +: DW]);
    end else begin
      chk("R5 unsynced no busy after", {31'b0, bus_busy}, 0);
      if (we) chk("R5 unsynced write visible", core_q[a*DW +: DW], exp_q(a));
      else    chk("R5 unsynced read data", bus_rdata, mdl_shadow[a]);
    end
  endtask

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(7));
    for (int i = 0; i < NREG; i++) begin mdl_shadow[i] = '0; mdl_core[i] = '0; end
    repeat (4) @(negedge bus_clk);
    bus_rst = 0; core_rst = 0;
    @(negedge bus_clk);
    chk("R10 busy reset", {31'b0, bus_busy}, 0);
    chk("R10 wait reset", {31'b0, bus_wait}, 0);
    chk("R10 ready reset", {31'b0, sync_ready}, 0);
    chk("R10 rdata reset", bus_rdata, 0);
    chk("R10 core_q reset", core_q[31:0], 0);

    for (int i = 0; i < NREG; i++) core_stat[i*DW +: DW] = DW'(16'hA000 + i);
    // R1: every class, write then read
    for (int i = 0; i < NREG; i++) access(1, i, DW'(16'h1100 * (i + 1)));
    for (int i = 0; i < NREG; i++) access(0, i, '0);

    // R6: synced write while busy is stalled, then taken
    bus_sel = 1; bus_we = 1; bus_addr = 2; bus_wdata = 16'h2222; #1;
    @(negedge bus_clk); mdl_shadow[2] = 16'h2222; mdl_core[2] = 16'h2222;
    bus_addr = 3; bus_wdata = 16'h3333; #1;
    chk("R6 wait while busy", {31'b0, bus_wait}, 1);
    // R5: unsynced write during pending write not stalled
    bus_addr = 7; bus_wdata = 16'h7777; #1;
    chk("R5 unsynced not stalled", {31'b0, bus_wait}, 0);
    @(negedge bus_clk); mdl_shadow[7] = 16'h7777;
    chk("R5 unsynced write during busy", core_q[7*DW +: DW], 16'h7777);
    bus_sel = 0;
    wait_idle("R6 first");
    chk("R3 first write done", core_q[2*DW +: DW], 16'h2222);
    access(1, 3, 16'h3333);

    // R9: unsynced read stalled by a pending synced read
    core_stat[4*DW +: DW] = 16'h4BCD;
    bus_sel = 1; bus_we = 0; bus_addr = 4; #1;
    @(negedge bus_clk);
    bus_addr = 6; #1;
    chk("R9 unsynced read stalled", {31'b0, bus_wait}, 1);
    bus_sel = 0;
    wait_idle("R9");
    chk("R7 pending read kept", bus_rdata, 16'h4BCD);

    // random mix
    for (int k = 0; k < 150; k++) begin
      int a = int'($urandom_range(NREG - 1));
      logic w = 1'($urandom_range(1));
      if (($urandom_range(3)) == 0) core_stat[a*DW +: DW] = DW'($urandom);
      access(w, a, DW'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule